// File: doc/BRIEF.md
# Register Busy-Bit Scoreboard

This block is the interlock for an in-order pipeline that has no forwarding paths. It keeps one busy flag for each architectural register. A flag is raised when an instruction that will write that register leaves the decode stage. The flag drops when the write-back stage delivers the result. While the instruction in decode names a source register whose flag is raised, the block asserts a stall, and decode holds that instruction.

The register file writes before it reads within a cycle. The flag of a register that write-back is writing in the current cycle is therefore treated as already clear. A consumer can leave decode in the same cycle that its producer writes back. With write-back three cycles after issue, a back-to-back dependent pair loses exactly two cycles.

Register 0 is hard-wired by default and is never tracked. A parameter can make it an ordinary register instead. If the same register is cleared by write-back and claimed by a new producer in the same cycle, the new claim is kept.

Top module: `regsb_interlock`

## Requirements
- R1: Reset clears every busy flag, and stall_o is low after reset.
- R2: stall_o is high when dec_valid_i is high and any source index names a register whose busy flag is set and is not being cleared this cycle. Source i sits at bits [i*IDX_W +: IDX_W] of dec_src_idx_i.
- R3: stall_o is low whenever dec_valid_i is low.
- R4: An instruction that leaves decode (dec_valid_i high, stall_o low) with dec_dst_wr_i high sets the flag of dec_dst_idx_i. The flag shows on busy_o from the next cycle.
- R5: wb_valid_i high clears the flag of wb_idx_i. The flag shows clear on busy_o from the next cycle.
- R6: A source whose flag is being cleared by write-back in the same cycle does not cause a stall.
- R7: With the default zero-register mode, bit 0 of busy_o is never set, and register 0 as a source never causes a stall.
- R8: When a set and a clear hit the same register in one cycle, the flag ends up set.
- R9: No flag is set by an instruction with dec_dst_wr_i low, or by a stalled instruction.
- R10: A consumer placed in decode the cycle after its producer issues, with the producer's write-back three cycles after issue, stalls for exactly two cycles.
- R11: When there is no write-back and no writing instruction leaves decode, busy_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid_i | input | 1 | An instruction is present in decode |
| dec_src_idx_i | input | NUM_SRC*IDX_W | Source register indices, packed, source 0 in the low bits |
| dec_dst_idx_i | input | IDX_W | Destination register index of the decode instruction |
| dec_dst_wr_i | input | 1 | The decode instruction writes its destination |
| wb_valid_i | input | 1 | Write-back writes a register this cycle |
| wb_idx_i | input | IDX_W | Register written by write-back |
| stall_o | output | 1 | Hold the decode instruction |
| busy_o | output | NUM_REGS | Busy flag per register |

## Verification
The assertions accept any register as a write-back target, including one whose flag is not set. They expect each index to lie within the register count, which a power-of-two NUM_REGS guarantees. The bench uses an eight-register, two-source setup. For each busy register it sweeps every source pair while driving complete, in-range indices. It raises write-back only for the intended register, at the cycle a three-stage gap after issue gives. The set-versus-clear collision is driven on purpose, because the assertions allow it.

// File: rtl/regsb_pkg.sv
package regsb_pkg;

   // Selects how register index 0 is treated by the scoreboard.
   typedef enum logic {
      ZR_HARDWIRED = 1'b0,   // index 0 reads as constant, never tracked
      ZR_ORDINARY  = 1'b1    // index 0 is tracked like any other register
   } zero_mode_e;

   localparam int unsigned DEF_NUM_REGS = 32;
   localparam int unsigned DEF_NUM_SRC  = 2;

   // True when v is a power of two and at least two.
   function automatic bit is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/regsb_idx_dec.sv
// Index-to-one-hot decoder with enable; zero-register handling picked by parameter.
module regsb_idx_dec #(
   parameter int unsigned         NUM_REGS  = regsb_pkg::DEF_NUM_REGS,
   parameter regsb_pkg::zero_mode_e ZERO_MODE = regsb_pkg::ZR_HARDWIRED,
   localparam int unsigned        IDX_W     = $clog2(NUM_REGS)
) (
   input  logic                en_i,
   input  logic [IDX_W-1:0]    idx_i,
   output logic [NUM_REGS-1:0] vec_o
);

   logic [NUM_REGS-1:0] raw;

   always_comb begin
      raw = '0;
      if (en_i) raw[idx_i] = 1'b1;
   end

   generate
      if (ZERO_MODE == regsb_pkg::ZR_HARDWIRED) begin : g_zero_hw
         assign vec_o = {raw[NUM_REGS-1:1], 1'b0};
      end else begin : g_zero_plain
         assign vec_o = raw;
      end
   endgenerate

endmodule

// File: rtl/regsb_src_probe.sv
// Looks up one source index in the effective busy view.
module regsb_src_probe #(
   parameter int unsigned NUM_REGS = regsb_pkg::DEF_NUM_REGS,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
   input  logic [NUM_REGS-1:0] view_i,
   input  logic [IDX_W-1:0]    idx_i,
   output logic                hit_o
);

   assign hit_o = view_i[idx_i];

endmodule

// File: rtl/regsb_busy_vec.sv
// Busy flag storage; a set in the same cycle as a clear wins.
module regsb_busy_vec #(
   parameter int unsigned NUM_REGS = regsb_pkg::DEF_NUM_REGS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_REGS-1:0] set_i,
   input  logic [NUM_REGS-1:0] clr_i,
   output logic [NUM_REGS-1:0] busy_o
);

   logic [NUM_REGS-1:0] busy_q;
   logic [NUM_REGS-1:0] busy_d;

   assign busy_d = (busy_q & ~clr_i) | set_i;

   always_ff @(posedge clk) begin
      if (!rst_n) busy_q <= '0;
      else        busy_q <= busy_d;
   end

   assign busy_o = busy_q;

endmodule

// File: rtl/regsb_interlock.sv
// Busy-bit scoreboard: holds decode on pending register writes.
module regsb_interlock #(
   parameter int unsigned           NUM_REGS  = regsb_pkg::DEF_NUM_REGS,
   parameter int unsigned           NUM_SRC   = regsb_pkg::DEF_NUM_SRC,
   parameter regsb_pkg::zero_mode_e ZERO_MODE = regsb_pkg::ZR_HARDWIRED,
   localparam int unsigned          IDX_W     = $clog2(NUM_REGS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     dec_valid_i,
   input  logic [NUM_SRC*IDX_W-1:0] dec_src_idx_i,
   input  logic [IDX_W-1:0]         dec_dst_idx_i,
   input  logic                     dec_dst_wr_i,
   input  logic                     wb_valid_i,
   input  logic [IDX_W-1:0]         wb_idx_i,
   output logic                     stall_o,
   output logic [NUM_REGS-1:0]      busy_o
);

   // Elaboration-time parameter checks.
   generate
      if (!regsb_pkg::is_pow2(NUM_REGS)) begin : g_bad_regs
         $error("regsb_interlock: NUM_REGS must be a power of two >= 2");
      end
      if (NUM_SRC < 1) begin : g_bad_src
         $error("regsb_interlock: NUM_SRC must be at least 1");
      end
   endgenerate

   logic [NUM_REGS-1:0] clr_vec;
   logic [NUM_REGS-1:0] set_vec;
   logic [NUM_REGS-1:0] busy_q;
   logic [NUM_REGS-1:0] busy_view;
   logic [NUM_SRC-1:0]  src_hit;
   logic                issue;

   // Write-back clear decode.
   regsb_idx_dec #(.NUM_REGS(NUM_REGS), .ZERO_MODE(ZERO_MODE)) u_clr_dec (
      .en_i  (wb_valid_i),
      .idx_i (wb_idx_i),
      .vec_o (clr_vec)
   );

   // Write-before-read: a register written this cycle already reads as free.
   assign busy_view = busy_q & ~clr_vec;

   // One lookup per source operand.
   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         regsb_src_probe #(.NUM_REGS(NUM_REGS)) u_probe (
            .view_i (busy_view),
            .idx_i  (dec_src_idx_i[s*IDX_W +: IDX_W]),
            .hit_o  (src_hit[s])
         );
      end
   endgenerate

   assign stall_o = dec_valid_i & (|src_hit);
   assign issue   = dec_valid_i & ~stall_o;

   // Destination claim for an instruction leaving decode.
   regsb_idx_dec #(.NUM_REGS(NUM_REGS), .ZERO_MODE(ZERO_MODE)) u_set_dec (
      .en_i  (issue & dec_dst_wr_i),
      .idx_i (dec_dst_idx_i),
      .vec_o (set_vec)
   );

   regsb_busy_vec #(.NUM_REGS(NUM_REGS)) u_busy (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec),
      .clr_i  (clr_vec),
      .busy_o (busy_q)
   );

   assign busy_o = busy_q;

endmodule

// File: rtl/regsb_interlock_chk.sv
// Property checker bound to regsb_interlock.
module regsb_interlock_chk #(
   parameter int unsigned NUM_REGS  = regsb_pkg::DEF_NUM_REGS,
   parameter bit          ZERO_HARD = 1'b1,
   localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                dec_valid_i,
   input logic [IDX_W-1:0]    dec_dst_idx_i,
   input logic                dec_dst_wr_i,
   input logic                wb_valid_i,
   input logic [IDX_W-1:0]    wb_idx_i,
   input logic                stall_o,
   input logic [NUM_REGS-1:0] busy_o
);

   logic leaves, claims;
   assign leaves = dec_valid_i && !stall_o;
   assign claims = leaves && dec_dst_wr_i && (!ZERO_HARD || dec_dst_idx_i != '0);

   assert_idle_no_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid_i |-> !stall_o);

   assert_stall_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |-> busy_o != '0);

   assert_set_on_leave_R4: assert property (@(posedge clk) disable iff (!rst_n)
      claims |=> busy_o[$past(dec_dst_idx_i)]);

   assert_clear_on_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid_i && !(claims && dec_dst_idx_i == wb_idx_i)) |=> !busy_o[$past(wb_idx_i)]);

   assert_same_cycle_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid_i && busy_o == (NUM_REGS'(1) << wb_idx_i)) |-> !stall_o);

   assert_zero_untracked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ZERO_HARD |-> !busy_o[0]);

   assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (claims && wb_valid_i && wb_idx_i == dec_dst_idx_i) |=> busy_o[$past(dec_dst_idx_i)]);

   assert_no_rise_without_claim_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(leaves && dec_dst_wr_i) |=> (busy_o & ~$past(busy_o)) == '0);

   assert_hold_when_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!wb_valid_i && !(leaves && dec_dst_wr_i)) |=> $stable(busy_o));

endmodule

bind regsb_interlock regsb_interlock_chk #(
   .NUM_REGS  (NUM_REGS),
   .ZERO_HARD (ZERO_MODE == regsb_pkg::ZR_HARDWIRED)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .dec_valid_i   (dec_valid_i),
   .dec_dst_idx_i (dec_dst_idx_i),
   .dec_dst_wr_i  (dec_dst_wr_i),
   .wb_valid_i    (wb_valid_i),
   .wb_idx_i      (wb_idx_i),
   .stall_o       (stall_o),
   .busy_o        (busy_o)
);

// File: tb/sim_regsb_interlock.sv
module sim_regsb_interlock;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int NR = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dv, wr, wbv;
   logic [2*IW-1:0] src;
   logic [IW-1:0] dst, wbi;
   logic          stall;
   logic [NR-1:0] busy;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   regsb_interlock #(.NUM_REGS(NR), .NUM_SRC(2)) u0 (
      .clk(clk), .rst_n(rst_n), .dec_valid_i(dv), .dec_src_idx_i(src),
      .dec_dst_idx_i(dst), .dec_dst_wr_i(wr), .wb_valid_i(wbv), .wb_idx_i(wbi),
      .stall_o(stall), .busy_o(busy)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Drive one decode/write-back pattern and let it settle.
   task automatic put(input logic v, input int s0, input int s1, input int d,
                      input logic w, input logic bv, input int bi);
      dv  = v;
      src = {IW'(s1), IW'(s0)};
      dst = IW'(d);
      wr  = w;
      wbv = bv;
      wbi = IW'(bi);
      #1;
   endtask

   task automatic idle();
      put(1'b0, 0, 0, 0, 1'b0, 1'b0, 0);
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic claim(input int r);
      put(1'b1, 0, 0, r, 1'b1, 1'b0, 0);
      tick();
      idle();
   endtask

   initial begin
      #(5.0 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int cnt;
      idle();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      chk("R1 busy after reset", int'(busy), 0);
      chk("R1 stall after reset", int'(stall), 0);

      // R4/R5/R7: claim and release every register.
      for (int r = 0; r < NR; r++) begin
         put(1'b1, 0, 0, r, 1'b1, 1'b0, 0);
         chk("R4 no stall on free sources", int'(stall), 0);
         tick();
         chk((r == 0) ? "R7 zero never busy" : "R4 claim visible", int'(busy),
             (r == 0) ? 0 : (1 << r));
         put(1'b0, 0, 0, 0, 1'b0, 1'b1, r);
         tick();
         chk("R5 release visible", int'(busy), 0);
      end

      // R2/R3/R6/R9: one busy register, every source pair.
      for (int b = 1; b < NR; b++) begin
         claim(b);
         for (int a = 0; a < NR; a++) begin
            for (int c = 0; c < NR; c++) begin
               put(1'b1, a, c, 0, 1'b0, 1'b0, 0);
               chk("R2 stall sweep", int'(stall), (a == b || c == b) ? 1 : 0);
            end
         end
         put(1'b0, b, b, 0, 1'b0, 1'b0, 0);
         chk("R3 no stall without valid", int'(stall), 0);
         put(1'b1, b, 0, 0, 1'b0, 1'b1, b);
         chk("R6 same-cycle write-back frees source", int'(stall), 0);
         put(1'b1, 0, b, (b == NR - 1) ? b - 1 : b + 1, 1'b1, 1'b0, 0);
         chk("R9 dependent stalls", int'(stall), 1);
         tick();
         chk("R9 stalled instr claims nothing", int'(busy), 1 << b);
         put(1'b0, 0, 0, 0, 1'b0, 1'b1, b);
         tick();
         chk("R5 release after sweep", int'(busy), 0);
      end

      // R9: instruction without a register write claims nothing.
      put(1'b1, 0, 0, 3, 1'b0, 1'b0, 0);
      tick();
      chk("R9 non-writer claims nothing", int'(busy), 0);

      // R8: set wins over clear on the same register.
      claim(4);
      put(1'b1, 0, 0, 4, 1'b1, 1'b1, 4);
      tick();
      chk("R8 set beats clear", int'(busy), 1 << 4);
      put(1'b0, 0, 0, 0, 1'b0, 1'b1, 4);
      tick();
      chk("R8 later clear", int'(busy), 0);

      // R11: quiet cycles hold state; write-back to a free register changes nothing else.
      claim(2);
      for (int k = 0; k < 3; k++) begin
         tick();
         chk("R11 hold while quiet", int'(busy), 1 << 2);
      end
      put(1'b0, 0, 0, 0, 1'b0, 1'b1, 5);
      tick();
      chk("R11 unrelated release", int'(busy), 1 << 2);
      put(1'b0, 0, 0, 0, 1'b0, 1'b1, 2);
      tick();
      chk("R5 release r2", int'(busy), 0);

      // R10: producer of r2, then consumer of r2 writing r4.
      put(1'b1, 1, 0, 2, 1'b1, 1'b0, 0);
      tick();
      cnt = 0;
      for (int k = 1; k <= 6; k++) begin
         put(1'b1, 2, 3, 4, 1'b1, (k == 3), 2);
         if (!stall) begin
            tick();
            break;
         end
         cnt++;
         tick();
      end
      idle();
      chk("R10 load-use stall cycles", cnt, 2);
      chk("R10 consumer claimed r4", int'(busy), 1 << 4);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule